// File: doc/BRIEF.md
# Trap Dispatch and Vector Generator

This block decides how a pending trap is delivered and where execution resumes. When a trap request arrives it looks at the current trap level, the privileged and hyperprivileged state bits, the recovery-state bit and the privilege level the trap targets. From these it chooses one of four delivery modes: normal privileged, hyperprivileged, recovery (RED) or error. It then forms the handler program counter from one of three vector tables. Each table masks its base register differently.

A trap sequencer drives the block with a one-cycle request and gets back, one clock later, a one-cycle valid strobe together with the following registered values:

- the mode;
- the trap type to record;
- the trap type that indexed the table;
- the decoded current privilege level;
- the handler PC and the two addresses that follow it.

Saving the architectural state and ranking competing traps are done elsewhere.

Top module: `tdv_trap_dispatch`

## Requirements
- R1: `cur_lvl_o` reports the level in force when the request was taken. It is 0 (user) when `pstate_priv_i` is 0. It is 1 (privileged) when `pstate_priv_i` is 1 and `hpstate_hpriv_i` is 0. It is 2 (hyperprivileged) when both are 1.
- R2: RED mode is selected, with `mode_o`=2, when `hpstate_red_i` is 1 or when the trap level equals MAX_TL-1. In RED mode `vec_tt_o`=5 and the PC is RED_BASE OR ((5<<5) AND 0xFF).
- R3: Error mode is selected, with `mode_o`=3, when the trap level equals MAX_TL and RED mode is not selected. In error mode the PC, NPC and NNPC are all 0.
- R4: The watchdog path applies when RED and error mode are not selected, the trap level exceeds MAX_PTL and `tgt_hyper_i` is 0. It gives `mode_o`=1 and `vec_tt_o`=2, with the PC taken from the hyperprivileged table.
- R5: When `tgt_hyper_i` is 1 and neither RED nor error mode is selected, `mode_o`=1 and `vec_tt_o` equals the trap type. The PC is HTBA with bits 13:0 cleared, OR ((type<<5) masked to 14 bits).
- R6: In every other case `mode_o`=0 and `vec_tt_o` equals the trap type. The PC is TBA with bits 14:0 cleared, OR bit 14 when the incoming trap level is at least 1, OR ((type<<5) masked to 14 bits).
- R7: Outside error mode, NPC = PC+4 and NNPC = PC+8.
- R8: `vld_o` is 1 in exactly the cycle after a cycle with `req_i`=1. With no request, every other output holds its value.
- R9: `rec_tt_o` equals the requested trap type in every mode.
- R10: After reset, `vld_o`, `mode_o`, `rec_tt_o`, `vec_tt_o`, `cur_lvl_o` and all three addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Trap request strobe |
| trap_type_i | input | 9 | Type of the pending trap |
| cur_tl_i | input | TL_W | Trap level before the trap |
| pstate_priv_i | input | 1 | Privileged-state bit |
| hpstate_hpriv_i | input | 1 | Hyperprivileged-state bit |
| hpstate_red_i | input | 1 | Recovery-state bit |
| tgt_hyper_i | input | 1 | Trap targets hyperprivileged level |
| tba_i | input | 64 | Privileged table base |
| htba_i | input | 64 | Hyperprivileged table base |
| vld_o | output | 1 | Result valid strobe |
| mode_o | output | 2 | 0 privileged, 1 hyper, 2 RED, 3 error |
| rec_tt_o | output | 9 | Trap type to record |
| vec_tt_o | output | 9 | Trap type used to index the table |
| cur_lvl_o | output | 2 | Decoded current level |
| pc_o | output | 64 | Handler PC |
| npc_o | output | 64 | Handler next PC |
| nnpc_o | output | 64 | Handler PC after next |

## Verification
Escalation to RED and the watchdog redirect can both qualify in the same cycle. With the default sizes, a trap level of MAX_TL-1 already exceeds MAX_PTL, and the recovery bit can be raised at any level above MAX_PTL. The sweep covers every trap level together with both values of the recovery bit and of the target level, so these overlaps occur many times. Each result is judged against a model in which RED takes precedence: the mode must be 2, the index type 5 and the PC the RED vector, never the watchdog vector. The same sweep also sets the recovery bit at MAX_TL, where RED must win over error mode.

// File: rtl/tdv_pkg.sv
`timescale 1ns/1ps
package tdv_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned TT_W       = 9;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned TT_SHIFT   = 5;
  localparam int unsigned RED_KEEP   = 8;
  localparam int unsigned HYP_KEEP   = 14;
  localparam int unsigned PRIV_KEEP  = 15;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TT_W-1:0]   tt_t;

  typedef enum logic [1:0] {
    MODE_PRIV  = 2'd0,
    MODE_HYPER = 2'd1,
    MODE_RED   = 2'd2,
    MODE_ERROR = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } lvl_e;

  localparam tt_t TT_RED_VEC  = tt_t'(5);
  localparam tt_t TT_WDOG_VEC = tt_t'(2);

  function automatic addr_t low_mask(input int unsigned keep);
    return (addr_t'(1) << keep) - addr_t'(1);
  endfunction

  function automatic addr_t tt_offset(input tt_t tt, input int unsigned keep);
    return (addr_t'(tt) << TT_SHIFT) & low_mask(keep);
  endfunction

  function automatic addr_t red_pc(input addr_t base, input tt_t tt);
    return base | tt_offset(tt, RED_KEEP);
  endfunction

  function automatic addr_t hyp_pc(input addr_t htba, input tt_t tt);
    return (htba & ~low_mask(HYP_KEEP)) | tt_offset(tt, HYP_KEEP);
  endfunction

  function automatic addr_t priv_pc(input addr_t tba, input tt_t tt, input logic deep);
    addr_t hi;
    hi = deep ? (addr_t'(1) << HYP_KEEP) : '0;
    return (tba & ~low_mask(PRIV_KEEP)) | hi | tt_offset(tt, HYP_KEEP);
  endfunction

  function automatic addr_t step_pc(input addr_t pc, input int unsigned n);
    return pc + addr_t'(n * INSN_BYTES);
  endfunction
endpackage

// File: rtl/tdv_level_decode.sv
`timescale 1ns/1ps
module tdv_level_decode
  import tdv_pkg::*;
(
  input  logic priv_i,
  input  logic hpriv_i,
  output lvl_e lvl_o
);
  always_comb begin
    if (!priv_i)      lvl_o = LVL_USER;
    else if (!hpriv_i) lvl_o = LVL_PRIV;
    else              lvl_o = LVL_HYPER;
  end
endmodule

// File: rtl/tdv_mode_select.sv
`timescale 1ns/1ps
module tdv_mode_select
  import tdv_pkg::*;
#(
  parameter int unsigned TL_W    = 3,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic [TL_W-1:0] tl_i,
  input  logic            red_i,
  input  logic            tgt_hyper_i,
  input  tt_t             tt_i,
  output mode_e           mode_o,
  output tt_t             vec_tt_o,
  output logic            deep_o,
  output logic            red_hit_o,
  output logic            err_hit_o,
  output logic            wdog_hit_o
);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PCAP = TL_W'(MAX_PTL);

  assign red_hit_o  = red_i || (tl_i == TL_RED);
  assign err_hit_o  = !red_hit_o && (tl_i == TL_ERR);
  assign wdog_hit_o = !red_hit_o && !err_hit_o && !tgt_hyper_i && (tl_i > TL_PCAP);
  assign deep_o     = (tl_i != '0);

  always_comb begin
    mode_o   = MODE_PRIV;
    vec_tt_o = tt_i;
    if (red_hit_o) begin
      mode_o   = MODE_RED;
      vec_tt_o = TT_RED_VEC;
    end else if (err_hit_o) begin
      mode_o   = MODE_ERROR;
    end else if (wdog_hit_o) begin
      mode_o   = MODE_HYPER;
      vec_tt_o = TT_WDOG_VEC;
    end else if (tgt_hyper_i) begin
      mode_o   = MODE_HYPER;
    end
  end
endmodule

// File: rtl/tdv_vector_calc.sv
`timescale 1ns/1ps
module tdv_vector_calc
  import tdv_pkg::*;
#(
  parameter addr_t       RED_BASE = 64'hFFFF_FFFF_F000_0000,
  parameter int unsigned N_SEQ    = 3
) (
  input  mode_e mode_i,
  input  tt_t   vec_tt_i,
  input  logic  deep_i,
  input  addr_t tba_i,
  input  addr_t htba_i,
  output addr_t seq_o [N_SEQ]
);
  addr_t base_pc;

  always_comb begin
    unique case (mode_i)
      MODE_RED:   base_pc = red_pc(RED_BASE, vec_tt_i);
      MODE_HYPER: base_pc = hyp_pc(htba_i, vec_tt_i);
      MODE_PRIV:  base_pc = priv_pc(tba_i, vec_tt_i, deep_i);
      default:    base_pc = '0;
    endcase
  end

  for (genvar k = 0; k < N_SEQ; k++) begin : g_seq
    assign seq_o[k] = (mode_i == MODE_ERROR) ? '0 : step_pc(base_pc, k);
  end
endmodule

// File: rtl/tdv_trap_dispatch.sv
`timescale 1ns/1ps
module tdv_trap_dispatch
  import tdv_pkg::*;
#(
  parameter int unsigned TL_W     = 3,
  parameter int unsigned MAX_TL   = 6,
  parameter int unsigned MAX_PTL  = 2,
  parameter logic [63:0] RED_BASE = 64'hFFFF_FFFF_F000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [8:0]      trap_type_i,
  input  logic [TL_W-1:0] cur_tl_i,
  input  logic            pstate_priv_i,
  input  logic            hpstate_hpriv_i,
  input  logic            hpstate_red_i,
  input  logic            tgt_hyper_i,
  input  logic [63:0]     tba_i,
  input  logic [63:0]     htba_i,
  output logic            vld_o,
  output logic [1:0]      mode_o,
  output logic [8:0]      rec_tt_o,
  output logic [8:0]      vec_tt_o,
  output logic [1:0]      cur_lvl_o,
  output logic [63:0]     pc_o,
  output logic [63:0]     npc_o,
  output logic [63:0]     nnpc_o
);
  localparam int unsigned N_SEQ = 3;

  lvl_e  lvl_d;
  mode_e mode_d;
  tt_t   vec_tt_d;
  logic  deep_d;
  logic  red_hit, err_hit, wdog_hit;
  addr_t seq_d [N_SEQ];

  tdv_level_decode u_lvl (
    .priv_i  (pstate_priv_i),
    .hpriv_i (hpstate_hpriv_i),
    .lvl_o   (lvl_d)
  );

  tdv_mode_select #(.TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) u_sel (
    .tl_i        (cur_tl_i),
    .red_i       (hpstate_red_i),
    .tgt_hyper_i (tgt_hyper_i),
    .tt_i        (trap_type_i),
    .mode_o      (mode_d),
    .vec_tt_o    (vec_tt_d),
    .deep_o      (deep_d),
    .red_hit_o   (red_hit),
    .err_hit_o   (err_hit),
    .wdog_hit_o  (wdog_hit)
  );

  tdv_vector_calc #(.RED_BASE(RED_BASE), .N_SEQ(N_SEQ)) u_vec (
    .mode_i   (mode_d),
    .vec_tt_i (vec_tt_d),
    .deep_i   (deep_d),
    .tba_i    (tba_i),
    .htba_i   (htba_i),
    .seq_o    (seq_d)
  );

  mode_e mode_q;
  lvl_e  lvl_q;
  logic  vld_q;
  tt_t   rec_tt_q, vec_tt_q;
  addr_t pc_q, npc_q, nnpc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      mode_q   <= MODE_PRIV;
      lvl_q    <= LVL_USER;
      rec_tt_q <= '0;
      vec_tt_q <= '0;
      pc_q     <= '0;
      npc_q    <= '0;
      nnpc_q   <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        mode_q   <= mode_d;
        lvl_q    <= lvl_d;
        rec_tt_q <= trap_type_i;
        vec_tt_q <= vec_tt_d;
        pc_q     <= seq_d[0];
        npc_q    <= seq_d[1];
        nnpc_q   <= seq_d[2];
      end
    end
  end

  assign vld_o     = vld_q;
  assign mode_o    = mode_q;
  assign cur_lvl_o = lvl_q;
  assign rec_tt_o  = rec_tt_q;
  assign vec_tt_o  = vec_tt_q;
  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign nnpc_o    = nnpc_q;
endmodule

// File: rtl/tdv_trap_dispatch_chk.sv
`timescale 1ns/1ps
module tdv_trap_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        red_hit,
  input logic        wdog_hit,
  input logic        vld_o,
  input logic [1:0]  mode_o,
  input logic [8:0]  rec_tt_o,
  input logic [8:0]  vec_tt_o,
  input logic [1:0]  cur_lvl_o,
  input logic [63:0] pc_o,
  input logic [63:0] npc_o,
  input logic [63:0] nnpc_o
);
  a_r8_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  a_r8_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(pc_o) && $stable(mode_o) && $stable(rec_tt_o)));
  a_r3_error_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && mode_o == 2'd3) |-> (pc_o == 64'd0 && npc_o == 64'd0 && nnpc_o == 64'd0));
  a_r7_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && mode_o != 2'd3) |-> (npc_o == pc_o + 64'd4 && nnpc_o == pc_o + 64'd8));
  a_r2_red_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && red_hit) |=> (mode_o == 2'd2 && vec_tt_o == 9'd5));
  a_r4_wdog_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wdog_hit) |=> (mode_o == 2'd1 && vec_tt_o == 9'd2));
  a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (cur_lvl_o != 2'd3));
endmodule

bind tdv_trap_dispatch tdv_trap_dispatch_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .red_hit   (red_hit),
  .wdog_hit  (wdog_hit),
  .vld_o     (vld_o),
  .mode_o    (mode_o),
  .rec_tt_o  (rec_tt_o),
  .vec_tt_o  (vec_tt_o),
  .cur_lvl_o (cur_lvl_o),
  .pc_o      (pc_o),
  .npc_o     (npc_o),
  .nnpc_o    (nnpc_o)
);

// File: tb/tdv_trap_dispatch_tb_top.sv
`timescale 1ns/1ps
module tdv_trap_dispatch_tb_top;
  localparam int TLW = 3;
  localparam logic [63:0] REDB = 64'hFFFF_FFFF_F000_0000;
  localparam logic [63:0] TBA  = 64'hA5A5_1234_5678_FFFF;
  localparam logic [63:0] HTBA = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [8:0] tt = '0;
  logic [TLW-1:0] tl = '0;
  logic pv = 1'b0, hp = 1'b0, red = 1'b0, tgh = 1'b0;
  logic vld;
  logic [1:0] mode, lvl;
  logic [8:0] rtt, vtt;
  logic [63:0] pc, npc, nnpc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tdv_trap_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .trap_type_i(tt), .cur_tl_i(tl),
    .pstate_priv_i(pv), .hpstate_hpriv_i(hp), .hpstate_red_i(red),
    .tgt_hyper_i(tgh), .tba_i(TBA), .htba_i(HTBA), .vld_o(vld), .mode_o(mode),
    .rec_tt_o(rtt), .vec_tt_o(vtt), .cur_lvl_o(lvl), .pc_o(pc), .npc_o(npc),
    .nnpc_o(nnpc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  localparam logic [8:0] TTS [6] = '{9'h000, 9'h024, 9'h05F, 9'h0A3, 9'h100, 9'h1FF};

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic        e_red, e_err, e_wd;
    logic [1:0]  e_mode, e_lvl;
    logic [8:0]  e_vt;
    logic [63:0] e_pc, hold_pc;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 vld", 64'(vld), 0);
    chk("R10 mode", 64'(mode), 0);
    chk("R10 pc", pc, 0);
    chk("R10 nnpc", nnpc, 0);
    chk("R10 rec_tt", 64'(rtt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t <= 6; t++)
      for (int r = 0; r < 2; r++)
        for (int g = 0; g < 2; g++)
          for (int l = 0; l < 4; l++)
            for (int ti = 0; ti < 6; ti++) begin
              tl = TLW'(t); red = r[0]; tgh = g[0];
              pv = l[0]; hp = l[1]; tt = TTS[ti]; req = 1'b1;
              e_red = red || (t == 5);
              e_err = !e_red && (t == 6);
              e_wd  = !e_red && !e_err && !tgh && (t > 2);
              e_mode = e_red ? 2'd2 : e_err ? 2'd3 : (e_wd || tgh) ? 2'd1 : 2'd0;
              e_vt  = e_red ? 9'd5 : e_wd ? 9'd2 : tt;
              case (e_mode)
                2'd2:    e_pc = {REDB[63:8], 8'hA0};
                2'd3:    e_pc = '0;
                2'd1:    e_pc = {HTBA[63:14], e_vt, 5'b0};
                default: e_pc = {TBA[63:15], (t != 0), tt, 5'b0};
              endcase
              e_lvl = !pv ? 2'd0 : !hp ? 2'd1 : 2'd2;
              @(negedge clk);
              req = 1'b0;
              chk("R8 vld high", 64'(vld), 1);
              chk(e_red ? "R2 mode" : e_err ? "R3 mode" : e_wd ? "R4 mode" : tgh ? "R5 mode" : "R6 mode",
                  64'(mode), 64'(e_mode));
              chk(e_red ? "R2 vec_tt" : e_wd ? "R4 vec_tt" : "R5 R6 vec_tt", 64'(vtt), 64'(e_vt));
              chk(e_err ? "R3 pc" : e_red ? "R2 pc" : e_wd ? "R4 pc" : tgh ? "R5 pc" : "R6 pc", pc, e_pc);
              chk(e_err ? "R3 npc" : "R7 npc", npc, e_err ? 64'd0 : e_pc + 64'd4);
              chk(e_err ? "R3 nnpc" : "R7 nnpc", nnpc, e_err ? 64'd0 : e_pc + 64'd8);
              chk("R9 rec_tt", 64'(rtt), 64'(tt));
              chk("R1 level", 64'(lvl), 64'(e_lvl));
              hold_pc = pc;
              // idle inputs change; outputs must hold
              tt = ~tt; tl = TLW'(0); red = ~red;
              @(negedge clk);
              chk("R8 vld low", 64'(vld), 0);
              chk("R8 hold pc", pc, hold_pc);
            end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule